// File: doc/BRIEF.md
# Dual-Clock 32-bit Tick Counter with Byte Register Access

This block is a 32-bit up-counter that lives in a slow counter clock domain. It is programmed from a faster bus clock through a small 8-bit register bus. The count, period and compare values are each spread over four byte registers. Lower bytes are held in a staging buffer, and only the write of the most significant byte commits the full word and starts its transfer into the counter domain. A separate request copies the running count back into the bus domain so that it can be read.

In fast mode the counter steps once per counter-clock cycle. In slow mode it steps only on the cycles where the `sec_tick` strobe is high. A debug-halt input freezes counting. On reaching the period value the counter wraps to zero at the next tick and raises an overflow event. A compare event is raised on the tick that follows the one on which the count equals the compare value. Both events set sticky flags in the bus domain and pulse event outputs, and each flag has its own interrupt enable. Every value crossing between the two clocks uses a toggle handshake through two-flop synchronizers.

The bus is a plain write-strobe register port. `bus_rdata` is combinational from `bus_addr`, and the block never stalls a write, so it has no back-pressure. A commit to a wide register, or to the control register, while that register's previous transfer is still pending is dropped. Software waits for the busy bit first.

Top module: `rtc_xdom_counter`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, SYNC (address 1) reads 0, FLAGS (address 3) reads 0, `irq` is low, count bytes (addresses 4..7) read 0, and period bytes (8..11) and compare bytes (12..15) read 0xFF.
- R2: Byte k of count, period and compare sits at base+k, with bases 4, 8 and 12 and k=3 the most significant byte. A write to bytes 0..2 only stages data, so period and compare readback is unchanged. Writing byte 3 commits {byte3, staged byte2, staged byte1, staged byte0}, and period and compare readback then shows the committed word.
- R3: CTRL bit0 enables counting and bit1 selects the tick source. With bit1=0 the count steps once per counter-clock cycle. With bit1=1 it steps only on counter-clock cycles where `sec_tick` is high. With bit0=0 it holds.
- R4: When a tick occurs with the count equal to the period, the count becomes 0 and the overflow flag (FLAGS bit0) is set.
- R5: When a tick occurs with the count equal to the compare value, the compare flag (FLAGS bit1) is set. The flag therefore rises on the tick after the match, so a compare value N above the start count is flagged only after N+1 ticks.
- R6: Writing 1 to SYNC bit0 requests a count capture. Once busy has cleared, the count bytes read the count held at capture time.
- R7: SYNC bit1 (busy) is high from the bus cycle after a control commit, a count commit or a capture request until that transfer is acknowledged. Period and compare commits leave it low.
- R8: While `dbg_halt` is high, the count does not change.
- R9: Flags are sticky. Writing 1 to a FLAGS bit clears it, and writing 0 leaves it. If a set and a clear fall in the same cycle, the set wins. `ovf_evt` and `cmp_evt` pulse for one bus clock per event.
- R10: `irq` is high exactly when some flag is set whose enable bit in INTEN (address 2; bit0 overflow, bit1 compare) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst_n | input | 1 | Active-low reset, bus domain |
| rclk | input | 1 | Counter-domain clock |
| rrst_n | input | 1 | Active-low reset, counter domain |
| sec_tick | input | 1 | Slow tick strobe, counter domain |
| dbg_halt | input | 1 | Freezes the count while high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ovf_evt | output | 1 | One-cycle overflow event pulse |
| cmp_evt | output | 1 | One-cycle compare event pulse |
| irq | output | 1 | Interrupt request |

## Verification
Overflow and compare can occur on the same tick when the compare value equals the period. The bench provokes this by starting the count two below a period that equals the compare value and releasing exactly three ticks. It judges the outcome by both flags being set, each event output pulsing exactly once, and the captured count having wrapped to zero. A second case at the top of the 32-bit range checks the same wrap when the compare match on zero follows the overflow by one tick.

// File: rtl/rtc_xdom_pkg.sv
package rtc_xdom_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_SYNC = 1;
  localparam int ADDR_IEN  = 2;
  localparam int ADDR_FLAG = 3;
  localparam int BASE_WIDE = 4;   // first byte of the count register
  localparam int N_WIDE    = 3;   // count, period, compare
  localparam int WIDE_CNT  = 0;
  localparam int WIDE_PER  = 1;
  localparam int WIDE_CMP  = 2;
  // handshake channel indices
  localparam int HS_CNTW = 0;
  localparam int HS_PER  = 1;
  localparam int HS_CMP  = 2;
  localparam int HS_CTRL = 3;
  localparam int HS_CNTR = 4;
  localparam int N_HS    = 5;
  // event indices
  localparam int EV_OVF = 0;
  localparam int EV_CMP = 1;
  localparam int N_EV   = 2;
endpackage

// File: rtl/rtc_xdom_hs.sv
module rtc_xdom_hs #(
  parameter int SYNC_N = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_fire,
  output logic src_pend,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic              req;
  logic [SYNC_N-1:0] ack_sh;
  logic [SYNC_N:0]   dst_sh;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req    <= 1'b0;
      ack_sh <= '0;
    end else begin
      req    <= req ^ src_fire;
      ack_sh <= {ack_sh[SYNC_N-2:0], dst_sh[SYNC_N]};
    end
  end

  assign src_pend = req ^ ack_sh[SYNC_N-1];

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) dst_sh <= '0;
    else            dst_sh <= {dst_sh[SYNC_N-1:0], req};
  end

  assign dst_pulse = dst_sh[SYNC_N-1] ^ dst_sh[SYNC_N];

  AST_HS_PEND_AFTER_FIRE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_fire |=> src_pend); // R7
  AST_HS_SINGLE_PULSE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> !dst_pulse); // R6
endmodule

// File: rtl/rtc_xdom_pulse.sv
module rtc_xdom_pulse #(
  parameter int SYNC_N = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_fire,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic            tgl;
  logic [SYNC_N:0] sh;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl <= 1'b0;
    else            tgl <= tgl ^ src_fire;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sh <= '0;
    else            sh <= {sh[SYNC_N-1:0], tgl};
  end

  assign dst_pulse = sh[SYNC_N-1] ^ sh[SYNC_N];
endmodule

// File: rtl/rtc_cnt_core.sv
module rtc_cnt_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sec_tick,
  input  logic         dbg_halt,
  input  logic         ctrl_load,
  input  logic [1:0]   ctrl_val,
  input  logic         cnt_load,
  input  logic [W-1:0] cnt_val,
  input  logic         per_load,
  input  logic [W-1:0] per_val,
  input  logic         cmp_load,
  input  logic [W-1:0] cmp_val,
  input  logic         cap_req,
  output logic [W-1:0] cap_q,
  output logic         ovf_fire,
  output logic         cmp_fire
);
  logic         en_q, slow_q;
  logic [W-1:0] cnt_q, per_q, cmp_q;
  logic         tick, at_per, at_cmp;

  assign tick   = en_q && !dbg_halt && (slow_q ? sec_tick : 1'b1);
  assign at_per = (cnt_q == per_q);
  assign at_cmp = (cnt_q == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      slow_q   <= 1'b0;
      cnt_q    <= '0;
      per_q    <= '1;
      cmp_q    <= '1;
      cap_q    <= '0;
      ovf_fire <= 1'b0;
      cmp_fire <= 1'b0;
    end else begin
      if (ctrl_load) {slow_q, en_q} <= ctrl_val;
      if (per_load)  per_q <= per_val;
      if (cmp_load)  cmp_q <= cmp_val;
      if (cap_req)   cap_q <= cnt_q;
      if (cnt_load)  cnt_q <= cnt_val;
      else if (tick) cnt_q <= at_per ? '0 : cnt_q + W'(1);
      ovf_fire <= tick && !cnt_load && at_per;
      cmp_fire <= tick && !cnt_load && at_cmp;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && cnt_q == per_q) |=> (cnt_q == '0 && ovf_fire)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && cnt_q != per_q) |=> (cnt_q == $past(cnt_q) + W'(1))); // R3
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !cnt_load) |=> $stable(cnt_q)); // R8
  AST_CMP_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |-> $past(tick && cnt_q == cmp_q)); // R5
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_xdom_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [N_HS-1:0]   hs_pend,
  output logic [N_HS-1:0]   hs_fire,
  input  logic [N_EV-1:0]   ev_pulse,
  input  logic [W-1:0]      cap_in,
  output logic [1:0]        ctrl_sh,
  output logic [W-1:0]      cnt_sh,
  output logic [W-1:0]      per_sh,
  output logic [W-1:0]      cmp_sh,
  output logic              irq
);
  localparam int NB = W / 8;

  logic [7:0]      stg  [N_WIDE][NB-1];
  logic [W-1:0]    sh   [N_WIDE];
  logic [W-1:0]    cval [N_WIDE];
  logic [N_WIDE-1:0] msb_hit;
  logic [1:0]      ie_q, flag_q, clr;
  logic [W-1:0]    rd_q;
  logic            cap_pend_q, busy;

  always_comb begin
    for (int r = 0; r < N_WIDE; r++) begin
      for (int k = 0; k < NB - 1; k++) cval[r][k*8 +: 8] = stg[r][k];
      cval[r][W-1 -: 8] = wdata;
      msb_hit[r] = we && (addr == AW'(BASE_WIDE + r*NB + NB - 1));
    end
  end

  always_comb begin
    hs_fire          = '0;
    hs_fire[HS_CNTW] = msb_hit[WIDE_CNT] && !hs_pend[HS_CNTW];
    hs_fire[HS_PER]  = msb_hit[WIDE_PER] && !hs_pend[HS_PER];
    hs_fire[HS_CMP]  = msb_hit[WIDE_CMP] && !hs_pend[HS_CMP];
    hs_fire[HS_CTRL] = we && (addr == AW'(ADDR_CTRL)) && !hs_pend[HS_CTRL];
    hs_fire[HS_CNTR] = we && (addr == AW'(ADDR_SYNC)) && wdata[0] && !hs_pend[HS_CNTR];
  end

  assign clr  = (we && addr == AW'(ADDR_FLAG)) ? wdata[1:0] : 2'b00;
  assign busy = hs_pend[HS_CTRL] | hs_pend[HS_CNTW] | hs_pend[HS_CNTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_WIDE; r++) begin
        for (int k = 0; k < NB - 1; k++) stg[r][k] <= '0;
      end
      sh[WIDE_CNT] <= '0;
      sh[WIDE_PER] <= '1;
      sh[WIDE_CMP] <= '1;
      ctrl_sh    <= '0;
      ie_q       <= '0;
      flag_q     <= '0;
      rd_q       <= '0;
      cap_pend_q <= 1'b0;
    end else begin
      for (int r = 0; r < N_WIDE; r++) begin
        for (int k = 0; k < NB - 1; k++) begin
          if (we && addr == AW'(BASE_WIDE + r*NB + k)) stg[r][k] <= wdata;
        end
      end
      if (hs_fire[HS_CNTW]) sh[WIDE_CNT] <= cval[WIDE_CNT];
      if (hs_fire[HS_PER])  sh[WIDE_PER] <= cval[WIDE_PER];
      if (hs_fire[HS_CMP])  sh[WIDE_CMP] <= cval[WIDE_CMP];
      if (hs_fire[HS_CTRL]) ctrl_sh <= wdata[1:0];
      if (we && addr == AW'(ADDR_IEN)) ie_q <= wdata[1:0];
      flag_q     <= (flag_q & ~clr) | {ev_pulse[EV_CMP], ev_pulse[EV_OVF]};
      cap_pend_q <= hs_pend[HS_CNTR];
      if (cap_pend_q && !hs_pend[HS_CNTR]) rd_q <= cap_in;
    end
  end

  assign cnt_sh = sh[WIDE_CNT];
  assign per_sh = sh[WIDE_PER];
  assign cmp_sh = sh[WIDE_CMP];
  assign irq    = |(flag_q & ie_q);

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CTRL)) rdata = {6'b0, ctrl_sh};
    if (addr == AW'(ADDR_SYNC)) rdata = {6'b0, busy, hs_pend[HS_CNTR]};
    if (addr == AW'(ADDR_IEN))  rdata = {6'b0, ie_q};
    if (addr == AW'(ADDR_FLAG)) rdata = {6'b0, flag_q};
    for (int r = 0; r < N_WIDE; r++) begin
      for (int k = 0; k < NB; k++) begin
        if (addr == AW'(BASE_WIDE + r*NB + k))
          rdata = (r == WIDE_CNT) ? rd_q[k*8 +: 8] : sh[r][k*8 +: 8];
      end
    end
  end

  AST_LOW_BYTE_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(BASE_WIDE + NB)) |=> $stable(per_sh)); // R2
  AST_BUSY_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fire[HS_CTRL] |=> busy); // R7
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse[EV_OVF] |=> flag_q[0]); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !clr[1]) |=> flag_q[1]); // R9
endmodule

// File: rtl/rtc_xdom_counter.sv
module rtc_xdom_counter
  import rtc_xdom_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2,
  parameter int AW     = 4
) (
  input  logic          pclk,
  input  logic          prst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          sec_tick,
  input  logic          dbg_halt,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          ovf_evt,
  output logic          cmp_evt,
  output logic          irq
);
  logic [N_HS-1:0]  hs_fire, hs_pend, hs_pulse;
  logic [N_EV-1:0]  ev_fire, ev_pulse;
  logic [1:0]       ctrl_sh;
  logic [CNT_W-1:0] cnt_sh, per_sh, cmp_sh, cap;

  rtc_bus_regs #(.W(CNT_W), .AW(AW)) u_regs (
    .clk(pclk), .rst_n(prst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .hs_pend(hs_pend), .hs_fire(hs_fire), .ev_pulse(ev_pulse),
    .cap_in(cap), .ctrl_sh(ctrl_sh), .cnt_sh(cnt_sh), .per_sh(per_sh),
    .cmp_sh(cmp_sh), .irq(irq)
  );

  for (genvar i = 0; i < N_HS; i++) begin : g_hs
    rtc_xdom_hs #(.SYNC_N(SYNC_N)) u_hs (
      .src_clk(pclk), .src_rst_n(prst_n), .src_fire(hs_fire[i]), .src_pend(hs_pend[i]),
      .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_pulse(hs_pulse[i])
    );
  end

  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    rtc_xdom_pulse #(.SYNC_N(SYNC_N)) u_ev (
      .src_clk(rclk), .src_rst_n(rrst_n), .src_fire(ev_fire[i]),
      .dst_clk(pclk), .dst_rst_n(prst_n), .dst_pulse(ev_pulse[i])
    );
  end

  rtc_cnt_core #(.W(CNT_W)) u_core (
    .clk(rclk), .rst_n(rrst_n), .sec_tick(sec_tick), .dbg_halt(dbg_halt),
    .ctrl_load(hs_pulse[HS_CTRL]), .ctrl_val(ctrl_sh),
    .cnt_load(hs_pulse[HS_CNTW]), .cnt_val(cnt_sh),
    .per_load(hs_pulse[HS_PER]), .per_val(per_sh),
    .cmp_load(hs_pulse[HS_CMP]), .cmp_val(cmp_sh),
    .cap_req(hs_pulse[HS_CNTR]), .cap_q(cap),
    .ovf_fire(ev_fire[EV_OVF]), .cmp_fire(ev_fire[EV_CMP])
  );

  assign ovf_evt = ev_pulse[EV_OVF];
  assign cmp_evt = ev_pulse[EV_CMP];
endmodule

// File: tb/tb_rtc_xdom_counter.sv
module tb_rtc_xdom_counter;
  localparam int P_CLK = 10;
  localparam int R_HALF = 37;

  logic pclk = 0, rclk = 0, prst_n = 0, rrst_n = 0;
  logic sec_tick = 0, dbg_halt = 1, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ovf_evt, cmp_evt, irq;
  int n_chk = 0, n_err = 0, n_ovf = 0, n_cmp = 0;

  always #(P_CLK/2) pclk = ~pclk;
  always #(R_HALF) rclk = ~rclk;

  rtc_xdom_counter dut (
    .pclk(pclk), .prst_n(prst_n), .rclk(rclk), .rrst_n(rrst_n), .sec_tick(sec_tick),
    .dbg_halt(dbg_halt), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .irq(irq)
  );

  always @(negedge pclk) begin
    if (ovf_evt) n_ovf++;
    if (cmp_evt) n_cmp++;
  end

  typedef struct packed {
    logic [31:0] per;
    logic [31:0] cmp;
    logic [31:0] start;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'd100,        32'd50,  32'd10,         8'd20},
    '{32'd15,         32'd200, 32'd10,         8'd8},
    '{32'd1000,       32'd20,  32'd18,         8'd2},
    '{32'd1000,       32'd20,  32'd18,         8'd3},
    '{32'd40,         32'd40,  32'd38,         8'd3},
    '{32'd0,          32'd5,   32'd0,          8'd4},
    '{32'hFFFF_FFFF,  32'd0,   32'hFFFF_FFFE,  8'd3}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge pclk);
    bus_we = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge pclk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge pclk);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic wr32(input int base, input logic [31:0] v);
    for (int k = 0; k < 4; k++) wr(base + k, v[k*8 +: 8]);
  endtask

  task automatic rd32(input int base, output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin rd(base + k, b); v[k*8 +: 8] = b; end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int guard = 0;
    do begin rd(1, s); guard++; end while (s[1] && guard < 2000);
  endtask

  task automatic settle();
    repeat (4) @(negedge rclk);
  endtask

  task automatic read_count(output logic [31:0] v);
    wr(1, 8'h01);
    wait_idle();
    rd32(4, v);
  endtask

  task automatic run_ticks(input int n);
    @(negedge rclk); dbg_halt = 0;
    repeat (n) @(negedge rclk);
    dbg_halt = 1;
  endtask

  // requirement model: tick with count==period wraps and flags overflow,
  // tick with count==compare flags compare
  task automatic model(input vec_t v, output logic [31:0] c, output int no, output int nc);
    c = v.start; no = 0; nc = 0;
    for (int i = 0; i < int'(v.n); i++) begin
      if (c == v.cmp) nc++;
      if (c == v.per) begin no++; c = 0; end
      else c = c + 1;
    end
  endtask

  initial begin
    #(P_CLK * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic [31:0] v, ec;
    int eo, ecn, o0, c0;

    repeat (3) @(negedge rclk);
    prst_n = 1; rrst_n = 1;
    repeat (2) @(negedge pclk);

    // R1 reset state
    rd(0, b);  check("R1 ctrl", b, 8'h00);
    rd(1, b);  check("R1 sync", b, 8'h00);
    rd(3, b);  check("R1 flags", b, 8'h00);
    rd32(4, v); check("R1 count", v, 32'h0);
    rd32(8, v); check("R1 period", v, 32'hFFFF_FFFF);
    rd32(12, v); check("R1 compare", v, 32'hFFFF_FFFF);
    check("R1 irq", irq, 1'b0);

    // R2 staging: lower bytes do not commit
    wr(8, 8'h12); wr(9, 8'h34); wr(10, 8'h56);
    rd32(8, v); check("R2 staged only", v, 32'hFFFF_FFFF);
    wr(11, 8'h78);
    rd32(8, v); check("R2 msb commits", v, 32'h7856_3412);

    // R7 busy on control commit, not on period commit
    wr(0, 8'h01);
    rd(1, b); check("R7 busy after ctrl", b[1], 1'b1);
    wait_idle();
    rd(1, b); check("R7 busy cleared", b[1], 1'b0);
    wr32(8, 32'd500);
    rd(1, b); check("R7 no busy on period", b[1], 1'b0);
    settle();

    // vector table: R3 R4 R5 R6 R8 R9
    foreach (VECS[i]) begin
      wr(3, 8'h03);
      wr32(8, VECS[i].per);
      wr32(12, VECS[i].cmp);
      wr32(4, VECS[i].start);
      wait_idle();
      settle();
      o0 = n_ovf; c0 = n_cmp;
      run_ticks(int'(VECS[i].n));
      settle();
      model(VECS[i], ec, eo, ecn);
      read_count(v);
      check($sformatf("R3/R4 count vec%0d", i), v, ec);
      rd(3, b);
      check($sformatf("R4 ovf flag vec%0d", i), b[0], eo > 0);
      check($sformatf("R5 cmp flag vec%0d", i), b[1], ecn > 0);
      check($sformatf("R9 ovf pulses vec%0d", i), n_ovf - o0, eo);
      check($sformatf("R9 cmp pulses vec%0d", i), n_cmp - c0, ecn);
    end

    // R10 interrupt enables and R9 write-1-to-clear (both flags set by last vector)
    check("R10 irq masked", irq, 1'b0);
    wr(2, 8'h01); check("R10 irq ovf enabled", irq, 1'b1);
    wr(3, 8'h01); check("R10 irq after ovf clear", irq, 1'b0);
    rd(3, b); check("R9 cmp kept on ovf clear", b, 8'h02);
    wr(3, 8'h00); rd(3, b); check("R9 write 0 keeps", b, 8'h02);
    wr(2, 8'h02); check("R10 irq cmp enabled", irq, 1'b1);
    wr(3, 8'h02); check("R10 irq after cmp clear", irq, 1'b0);
    rd(3, b); check("R9 flags cleared", b, 8'h00);

    // R8 debug halt holds count with counter enabled
    wr32(8, 32'hFFFF_FFFF);
    wr32(4, 32'd7);
    wait_idle(); settle();
    repeat (20) @(negedge rclk);
    read_count(v); check("R8 halt holds", v, 32'd7);

    // R3 disabled counter holds
    wr(0, 8'h00); wait_idle(); settle();
    dbg_halt = 0; repeat (15) @(negedge rclk); dbg_halt = 1;
    read_count(v); check("R3 disabled holds", v, 32'd7);

    // R3 slow tick source
    wr(0, 8'h03); wait_idle();
    wr32(4, 32'd0); wait_idle(); settle();
    for (int i = 0; i < 50; i++) begin
      @(negedge rclk); dbg_halt = 0; sec_tick = (i % 5 == 0);
    end
    @(negedge rclk); dbg_halt = 1; sec_tick = 0;
    settle();
    read_count(v); check("R3 slow ticks", v, 32'd10);
    rd(0, b); check("R3 ctrl readback", b, 8'h03);

    // R6 capture stays stable until next request
    rd32(4, v); check("R6 capture stable", v, 32'd10);

    finish_run();
  end
endmodule